// File: doc/BRIEF.md
# Register-Bank I2C Target

This block is an I2C target that runs on a fast system clock and samples the bus lines through synchronizers. It decodes START and STOP conditions and answers one fixed 7-bit device address. On a write transfer the first byte after the address selects a register. Each byte after that is stored into the register bank. On a read transfer the block returns a single status byte.

The bank holds seven 8-bit control registers, and all of them are presented in parallel on output ports. A subaddress field chooses both the target register and the pointer policy. In the low range the pointer steps forward after each byte and wraps within eight slots. In the high range the pointer stays fixed, so one register can be rewritten over and over. One subaddress slot has no storage of its own: a byte written there lands in both volume registers at once. Synchronous reset acts as the power-on reset. It loads fixed defaults and raises a sticky "reset seen" flag. That flag is visible in the status byte until a read of that byte has been acknowledged.

The block only pulls SDA low (`sda_oe_o`). The SCL and SDA pads and the pull-ups sit outside it. It does not stretch the clock and does not answer the general call.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset the outputs hold ctl=88h, sel=00h, inp=0Eh, outp=01h, vol_l=40h, vol_r=40h, pwr=04h.
- R2: The device answers write address byte B8h and read address byte B9h (7-bit address 5Ch, with R/W in bit 0 and 1 meaning read). It ACKs the address, a valid subaddress and every data byte by pulling SDA low in the ninth clock.
- R3: A subaddress 0000_0xxx selects slot xxx: 0 ctl, 1 sel, 2 inp, 3 outp, 4 vol_l, 5 vol_r, 7 pwr. After each data byte the slot advances by one.
- R4: A subaddress 1111_0xxx selects the same slot, but the slot does not advance, so every data byte of the transfer goes to that one register and its neighbours stay unchanged.
- R5: A data byte written to slot 6 is stored in both vol_l and vol_r.
- R6: With auto-advance on, slot 6 advances to slot 7, and slot 7 wraps to slot 0.
- R7: An address byte other than B8h/B9h is not ACKed, and the rest of that transfer changes no register.
- R8: A subaddress outside both ranges is NACKed. The data bytes that follow it are NACKed and change no register until the next START.
- R9: The read byte is {status_i[2:0], rst_seen, 4'b0000}, MSB first. rst_seen is 1 after reset.
- R10: rst_seen clears once the master ACKs a transmitted read byte. Any byte sent after that, in the same transfer or a later one, carries 0 in bit 4.
- R11: A repeated START returns the target to the address phase, so a read can follow a write without an intervening STOP.
- R12: `sda_oe_o` changes only while SCL is low, except that it is released at START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst | input | 1 | Synchronous active-high reset, acts as power-on reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| status_i | input | 3 | Flags returned in read-byte bits 7..5 |
| ctl_o | output | 8 | Slot 0 register |
| sel_o | output | 8 | Slot 1 register |
| inp_o | output | 8 | Slot 2 register |
| outp_o | output | 8 | Slot 3 register |
| vol_l_o | output | 8 | Slot 4 register (left volume) |
| vol_r_o | output | 8 | Slot 5 register (right volume) |
| pwr_o | output | 8 | Slot 7 register |

## Verification
The bench targets the pointer edges. It writes a burst across slot 6 into slot 7 and one from slot 7 back to slot 0. A pointer that skipped the shared slot or failed to wrap would put these bytes into the wrong registers. Fixed-pointer bursts check that the register next to the target keeps its value, which catches a design that advances anyway. Bytes sent after a bad address or a bad subaddress must leave every register untouched and be NACKed. A design that kept decoding after a rejection would corrupt state. Reads before and after an acknowledged read byte, and across a repeated START, check that the reset flag clears at the right point and that the status bits sit in bits 7..5.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  localparam int DW       = 8;
  localparam int NSLOT    = 8;
  localparam int SLOTW    = $clog2(NSLOT);
  localparam int STATW    = 3;
  localparam logic [SLOTW-1:0] SLOT_VOL_L = 3'd4;
  localparam logic [SLOTW-1:0] SLOT_VOL_R = 3'd5;
  localparam logic [SLOTW-1:0] SLOT_DUAL  = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SUB, ST_WDAT, ST_ACK, ST_RDAT, ST_RACK, ST_SKIP
  } bus_state_t;

  function automatic logic [DW-1:0] slot_default(input int idx);
    case (idx)
      0:       return 8'h88;
      1:       return 8'h00;
      2:       return 8'h0E;
      3:       return 8'h01;
      4:       return 8'h40;
      5:       return 8'h40;
      7:       return 8'h04;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o    = scl_pipe[STAGES-1];
  assign sda_o    = sda_pipe[STAGES-1];
  assign scl_rise = scl_o & ~scl_d;
  assign scl_fall = ~scl_o & scl_d;
  // SDA moving while SCL stays high marks a bus condition
  assign start_o  = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o   = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [DW-1:0]    tx_byte,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [SLOTW-1:0] wr_idx,
  output logic [DW-1:0]    wr_data,
  output logic             rd_ack,
  output bus_state_t       state_o
);
  localparam int CNTW = $clog2(DW + 1);

  bus_state_t       state;
  bus_state_t       ret_state;
  logic [CNTW-1:0]  bitcnt;
  logic [DW-1:0]    shreg;
  logic [DW-1:0]    tx_sh;
  logic [SLOTW-1:0] ptr;
  logic             inc_en;
  logic             m_acked;
  logic             byte_in;
  logic             sub_inc;
  logic             sub_fix;

  assign byte_in = scl_fall && (bitcnt == CNTW'(DW));
  assign sub_inc = (shreg[7:3] == 5'b00000);
  assign sub_fix = (shreg[7:3] == 5'b11110);
  assign state_o = state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ret_state <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      inc_en    <= 1'b1;
      m_acked   <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      rd_ack    <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      rd_ack <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_WDAT: begin
            if (scl_rise) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_in) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe    <= 1'b1;
                  state     <= ST_ACK;
                  ret_state <= shreg[0] ? ST_RDAT : ST_SUB;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_SUB) begin
                if (sub_inc || sub_fix) begin
                  sda_oe    <= 1'b1;
                  ptr       <= shreg[SLOTW-1:0];
                  inc_en    <= sub_inc;
                  state     <= ST_ACK;
                  ret_state <= ST_WDAT;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                sda_oe    <= 1'b1;
                wr_en     <= 1'b1;
                wr_idx    <= ptr;
                wr_data   <= shreg;
                state     <= ST_ACK;
                ret_state <= ST_WDAT;
                if (inc_en) ptr <= ptr + 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state <= ret_state;
              if (ret_state == ST_RDAT) begin
                tx_sh  <= tx_byte;
                sda_oe <= ~tx_byte[DW-1];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == CNTW'(DW)) begin
                bitcnt <= '0;
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                sda_oe <= ~tx_sh[DW-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_acked <= ~sda_s;
              rd_ack  <= ~sda_s;
            end else if (scl_fall) begin
              if (m_acked) begin
                tx_sh  <= tx_byte;
                sda_oe <= ~tx_byte[DW-1];
                state  <= ST_RDAT;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_rb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [SLOTW-1:0]          wr_idx,
  input  logic [DW-1:0]             wr_data,
  input  logic                      flag_clr,
  input  logic [STATW-1:0]          status_i,
  output logic [NSLOT-1:0][DW-1:0]  bank_o,
  output logic [DW-1:0]             tx_byte_o,
  output logic                      rst_seen_o
);
  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      if (g == int'(SLOT_DUAL)) begin : g_shared
        assign bank_o[g] = '0;
      end else begin : g_store
        logic hit;
        assign hit = wr_en && ((wr_idx == SLOTW'(g)) ||
                     ((wr_idx == SLOT_DUAL) &&
                      ((SLOTW'(g) == SLOT_VOL_L) || (SLOTW'(g) == SLOT_VOL_R))));
        always_ff @(posedge clk) begin
          if (rst)      bank_o[g] <= slot_default(g);
          else if (hit) bank_o[g] <= wr_data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           rst_seen_o <= 1'b1;
    else if (flag_clr) rst_seen_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) tx_byte_o <= '0;
    else     tx_byte_o <= {status_i, rst_seen_o, {(DW-STATW-1){1'b0}}};
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h5C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [STATW-1:0] status_i,
  output logic [DW-1:0]    ctl_o,
  output logic [DW-1:0]    sel_o,
  output logic [DW-1:0]    inp_o,
  output logic [DW-1:0]    outp_o,
  output logic [DW-1:0]    vol_l_o,
  output logic [DW-1:0]    vol_r_o,
  output logic [DW-1:0]    pwr_o
);
  logic                     scl_s, sda_s, scl_rise, scl_fall;
  logic                     start_det, stop_det;
  logic                     wr_en, rd_ack, rst_seen;
  logic [SLOTW-1:0]         wr_idx;
  logic [DW-1:0]            wr_data, tx_byte;
  logic [NSLOT-1:0][DW-1:0] bank;
  logic [DW-1:0]            unused_shared;
  bus_state_t               eng_state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .tx_byte(tx_byte), .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_ack(rd_ack), .state_o(eng_state)
  );

  i2c_reg_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .flag_clr(rd_ack), .status_i(status_i), .bank_o(bank),
    .tx_byte_o(tx_byte), .rst_seen_o(rst_seen)
  );

  assign ctl_o         = bank[0];
  assign sel_o         = bank[1];
  assign inp_o         = bank[2];
  assign outp_o        = bank[3];
  assign vol_l_o       = bank[SLOT_VOL_L];
  assign vol_r_o       = bank[SLOT_VOL_R];
  assign unused_shared = bank[SLOT_DUAL];
  assign pwr_o         = bank[7];
endmodule

// File: rtl/i2c_regbank_checker.sv
module i2c_regbank_checker
  import i2c_rb_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_oe_o,
  input logic             wr_en,
  input logic [SLOTW-1:0] wr_idx,
  input logic             rd_ack,
  input logic             rst_seen,
  input bus_state_t       eng_state,
  input logic [DW-1:0]    ctl_o,
  input logic [DW-1:0]    sel_o,
  input logic [DW-1:0]    inp_o,
  input logic [DW-1:0]    outp_o,
  input logic [DW-1:0]    vol_l_o,
  input logic [DW-1:0]    vol_r_o,
  input logic [DW-1:0]    pwr_o
);
  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctl_o == 8'h88 && sel_o == 8'h00 && inp_o == 8'h0E &&
                    outp_o == 8'h01 && vol_l_o == 8'h40 && vol_r_o == 8'h40 &&
                    pwr_o == 8'h04));

  assert_dual_write_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == SLOT_DUAL) |=> (vol_l_o == vol_r_o));

  assert_no_ack_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (eng_state == ST_IDLE) |-> !sda_oe_o);

  assert_no_ack_skip_R8: assert property (@(posedge clk) disable iff (rst)
    (eng_state == ST_SKIP) |-> (!sda_oe_o && !wr_en));

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_seen) |-> $past(rd_ack));

  assert_sda_scl_low_R12: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe_o) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s));
endmodule

bind i2c_regbank_slave i2c_regbank_checker u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe_o(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx),
  .rd_ack(rd_ack), .rst_seen(rst_seen), .eng_state(eng_state),
  .ctl_o(ctl_o), .sel_o(sel_o), .inp_o(inp_o), .outp_o(outp_o),
  .vol_l_o(vol_l_o), .vol_r_o(vol_r_o), .pwr_o(pwr_o)
);

// File: tb/i2c_regbank_slave_test.sv
module i2c_regbank_slave_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [2:0] status = 3'b101;
  logic       sda_oe;
  logic       sda_bus;
  logic [7:0] ctl, sel, inp, outp, vol_l, vol_r, pwr;
  int         checks = 0;
  int         errors = 0;
  int         oe_viol = 0;
  bit         done = 0;
  logic       prev_scl = 1'b1;
  logic       prev_oe = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_regbank_slave uut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .status_i(status), .ctl_o(ctl), .sel_o(sel), .inp_o(inp), .outp_o(outp),
    .vol_l_o(vol_l), .vol_r_o(vol_r), .pwr_o(pwr)
  );

  // R12 monitor: target drive must not move while SCL is held high
  always @(negedge clk) begin
    if (!rst && m_scl && prev_scl && (sda_oe !== prev_oe)) oe_viol++;
    prev_scl = m_scl;
    prev_oe  = sda_oe;
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitc(15);
    m_scl = 1'b1; waitc(20);
    m_sda = 1'b0; waitc(20);
    m_scl = 1'b0; waitc(5);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitc(15);
    m_scl = 1'b1; waitc(20);
    m_sda = 1'b1; waitc(20);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      waitc(5);  m_sda = b[i];
      waitc(15); m_scl = 1'b1;
      waitc(20); m_scl = 1'b0;
    end
    waitc(5);  m_sda = 1'b1;
    waitc(15); m_scl = 1'b1;
    waitc(10); ack = ~sda_bus;
    waitc(10); m_scl = 1'b0;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(20); m_scl = 1'b1;
      waitc(10); d[i] = sda_bus;
      waitc(10); m_scl = 1'b0;
    end
    waitc(5);  m_sda = ~give_ack;
    waitc(15); m_scl = 1'b1;
    waitc(20); m_scl = 1'b0;
    waitc(5);  m_sda = 1'b1;
  endtask

  task automatic test_reset_R1();
    chk("R1 ctl", ctl, 8'h88);   chk("R1 sel", sel, 8'h00);
    chk("R1 inp", inp, 8'h0E);   chk("R1 outp", outp, 8'h01);
    chk("R1 vol_l", vol_l, 8'h40); chk("R1 vol_r", vol_r, 8'h40);
    chk("R1 pwr", pwr, 8'h04);
    chk("R1 sda idle", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic test_read_R9_R10();
    logic [7:0] d;
    bus_start();
    put_byte(8'hB9, d[0]); chk("R2 read address ack", {7'd0, d[0]}, 8'h01);
    get_byte(1'b1, d);     chk("R9 first read byte", d, 8'hB0);
    get_byte(1'b0, d);     chk("R10 flag cleared after ack", d, 8'hA0);
    bus_stop();
    status = 3'b011;
    bus_start();
    put_byte(8'hB9, d[0]);
    get_byte(1'b0, d);     chk("R10 flag stays clear, R9 status", d, 8'h60);
    bus_stop();
  endtask

  task automatic test_burst_R3();
    logic a;
    bus_start();
    put_byte(8'hB8, a); chk("R2 write address ack", {7'd0, a}, 8'h01);
    put_byte(8'h00, a); chk("R2 subaddress ack", {7'd0, a}, 8'h01);
    put_byte(8'hA1, a); chk("R2 data ack", {7'd0, a}, 8'h01);
    put_byte(8'hA2, a);
    put_byte(8'hA3, a);
    bus_stop();
    chk("R3 slot0", ctl, 8'hA1); chk("R3 slot1", sel, 8'hA2);
    chk("R3 slot2", inp, 8'hA3); chk("R3 slot3 untouched", outp, 8'h01);
  endtask

  task automatic test_fixed_R4();
    logic a;
    bus_start();
    put_byte(8'hB8, a); put_byte(8'hF3, a);
    chk("R4 fixed subaddress ack", {7'd0, a}, 8'h01);
    put_byte(8'h11, a); put_byte(8'h22, a); put_byte(8'h33, a);
    bus_stop();
    chk("R4 last byte kept", outp, 8'h33);
    chk("R4 neighbour untouched", vol_l, 8'h40);
    chk("R4 lower neighbour untouched", inp, 8'hA3);
  endtask

  task automatic test_dual_R5_R6();
    logic a;
    bus_start();
    put_byte(8'hB8, a); put_byte(8'h06, a);
    put_byte(8'h5A, a); put_byte(8'h9C, a);
    bus_stop();
    chk("R5 vol_l", vol_l, 8'h5A); chk("R5 vol_r", vol_r, 8'h5A);
    chk("R6 slot6 advances to 7", pwr, 8'h9C);
  endtask

  task automatic test_wrap_R6();
    logic a;
    bus_start();
    put_byte(8'hB8, a); put_byte(8'h07, a);
    put_byte(8'h7E, a); put_byte(8'h3C, a);
    bus_stop();
    chk("R6 slot7", pwr, 8'h7E); chk("R6 wrap to slot0", ctl, 8'h3C);
    chk("R6 slot1 untouched", sel, 8'hA2);
  endtask

  task automatic test_bad_addr_R7();
    logic a;
    bus_start();
    put_byte(8'hA0, a); chk("R7 foreign address nack", {7'd0, a}, 8'h00);
    put_byte(8'h00, a); chk("R7 following byte nack", {7'd0, a}, 8'h00);
    put_byte(8'hFF, a);
    bus_stop();
    chk("R7 slot0 unchanged", ctl, 8'h3C);
  endtask

  task automatic test_bad_sub_R8();
    logic a;
    bus_start();
    put_byte(8'hB8, a); put_byte(8'h08, a);
    chk("R8 bad subaddress nack", {7'd0, a}, 8'h00);
    put_byte(8'hFF, a); chk("R8 data after bad subaddress nack", {7'd0, a}, 8'h00);
    put_byte(8'hEE, a);
    bus_stop();
    chk("R8 slot0 unchanged", ctl, 8'h3C);
    chk("R8 slot1 unchanged", sel, 8'hA2);
    chk("R8 slot7 unchanged", pwr, 8'h7E);
  endtask

  task automatic test_rstart_R11();
    logic a;
    logic [7:0] d;
    status = 3'b010;
    bus_start();
    put_byte(8'hB8, a); put_byte(8'h01, a); put_byte(8'h5F, a);
    bus_start();
    put_byte(8'hB9, a); chk("R11 address after repeated start", {7'd0, a}, 8'h01);
    get_byte(1'b0, d);  chk("R11 read after repeated start", d, 8'h40);
    bus_stop();
    chk("R11 write before repeated start", sel, 8'h5F);
  endtask

  initial begin
    waitc(6);
    rst = 1'b0;
    waitc(4);
    test_reset_R1();
    test_read_R9_R10();
    test_burst_R3();
    test_fixed_R4();
    test_dual_R5_R6();
    test_wrap_R6();
    test_bad_addr_R7();
    test_bad_sub_R8();
    test_rstart_R11();
    chk("R12 drive changes only with SCL low", 8'(oe_viol), 8'h00);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule